// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Phase-Offset Counters

This block drives a bank of pulse-width-modulated outputs that all start their period on the same tick. A single shared counter of `CNT_W` bits marks the start of every period when it wraps to zero, and that sets every channel high. The period is 2^`CNT_W` ticks. Each channel has its own free-running counter of the same width. That counter runs a fixed phase distance behind the shared one, and when it wraps to zero it drives its channel low. The channel's duty value sets that phase distance, so a channel never compares a count against a threshold. Its edge comes from detecting zero on its own counter.

All counters advance only on clocks where the tick enable is high, so the PWM rate can be set by an external prescaler. Software or a neighbouring block writes a new duty word for each channel with a per-channel load strobe. The word is held pending and takes effect at the next period start, so a period is never cut short or stretched in the middle. A duty of zero gives a constant low output. A duty of 2^`CNT_W` or more gives a constant high output.

Top module: `pwm_phase_bank`

## Requirements
- R1: While reset is asserted and after it is released, every PWM bit is 1 and the period-start pulse is 0. The first period uses the duty `DUTY_RST` on every channel, with the tick phase starting at 0.
- R2: On a clock where `tick_en_i` is 0, no PWM bit changes and the period-start pulse is 0.
- R3: The tick phase counts enabled ticks since the last period start, modulo P = 2^`CNT_W`. A channel whose active duty d lies in 1..P-1 outputs 1 at phases 0..d-1 and outputs 0 at phases d..P-1. All channels rise on the same tick.
- R4: A channel with active duty 0 outputs 0 at every phase, including phase 0.
- R5: A channel with active duty of P or more outputs 1 at every phase.
- R6: When bit c of `duty_load_i` is 1, the bits `duty_i[c*DUTY_W +: DUTY_W]` are captured as channel c's pending duty. The active duty takes the pending value on the enabled tick that brings the phase to 0. A load on that same clock applies only at the following period start. Other channels are not affected.
- R7: `period_start_o` is 1 for exactly the clock after each enabled tick that brings the phase to 0. In that clock the PWM bits show their phase-0 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en_i | input | 1 | Advance all counters by one on this clock |
| duty_load_i | input | NUM_CH | Per-channel strobe that captures the channel's duty slice |
| duty_i | input | NUM_CH*DUTY_W | Duty words, channel c in bits c*DUTY_W +: DUTY_W |
| pwm_o | output | NUM_CH | Registered PWM outputs, bit c for channel c |
| period_start_o | output | 1 | One-clock pulse at each period start |

## Verification
The bench targets the duty extremes 0, 1, P-1, P and values above P. A design that let the reload alias would glitch high for a tick at duty 0, or fall low at duty P. It also loads a duty on the exact clock of a period start and expects that value to wait one more period. A design that forwarded the load early would change the high time one period too soon. Long gaps in the tick enable check that nothing moves between ticks. Comparing every channel on every clock catches a channel that reacts to another channel's strobe.

// File: rtl/pwm_ps_pkg.sv
package pwm_ps_pkg;

  // Lowest bit index of channel ch inside a flat bus of w-bit words.
  function automatic int unsigned lane_lo(input int unsigned ch, input int unsigned w);
    return ch * w;
  endfunction

endpackage

// File: rtl/pwm_rise_ctr.sv
// Shared period counter. Wraps every 2^CNT_W enabled ticks.
module pwm_rise_ctr #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    cnt_inc = cnt_q + CNT_W'(1);
    cnt_d   = cnt_q;
    if (tick_en_i) begin
      cnt_d = cnt_inc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign wrap_o = tick_en_i && (cnt_inc == '0);
  assign cnt_o  = cnt_q;

  AST_RISE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_en_i |=> $stable(cnt_q)); // R2

  AST_RISE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_en_i |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)))); // R3

endmodule

// File: rtl/pwm_fall_chan.sv
// One output channel: pending/active duty, phase-offset counter, output bit.
module pwm_fall_chan #(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned DUTY_W   = CNT_W + 1,
  parameter int unsigned DUTY_RST = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              rise_wrap_i,
  input  logic [CNT_W-1:0]  rise_cnt_i,
  input  logic              load_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);

  localparam logic [DUTY_W-1:0] PERIOD   = DUTY_W'(1) << CNT_W;
  localparam logic [DUTY_W-1:0] RST_DUTY = DUTY_W'(DUTY_RST);
  localparam logic [CNT_W-1:0]  RST_LO   = (RST_DUTY >= PERIOD) ? '0 : RST_DUTY[CNT_W-1:0];
  localparam logic [CNT_W-1:0]  RST_FALL = CNT_W'(0) - RST_LO;

  logic [DUTY_W-1:0] pend_q, pend_d;
  logic [DUTY_W-1:0] act_q, act_d;
  logic [CNT_W-1:0]  fall_q, fall_d;
  logic              pwm_q, pwm_d;
  logic              full_d;
  logic [CNT_W-1:0]  lo_d;
  logic [CNT_W-1:0]  reload;
  logic              fall_wrap;
  logic              act_full_q;
  logic [CNT_W-1:0]  act_lo_q;

  // Next-state logic
  always_comb begin
    pend_d    = load_i ? duty_i : pend_q;
    act_d     = rise_wrap_i ? pend_q : act_q;
    full_d    = (act_d >= PERIOD);
    lo_d      = full_d ? '0 : act_d[CNT_W-1:0];
    reload    = CNT_W'(0) - lo_d;
    fall_d    = fall_q;
    fall_wrap = 1'b0;
    if (tick_en_i) begin
      if (rise_wrap_i) begin
        fall_d = reload;
      end else begin
        fall_d = fall_q + CNT_W'(1);
      end
      fall_wrap = (fall_d == '0) && !full_d;
    end
    pwm_d = pwm_q;
    if (rise_wrap_i) begin
      pwm_d = 1'b1;
    end
    if (fall_wrap) begin
      pwm_d = 1'b0;
    end
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= RST_DUTY;
      act_q  <= RST_DUTY;
      fall_q <= RST_FALL;
      pwm_q  <= 1'b1;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      fall_q <= fall_d;
      pwm_q  <= pwm_d;
    end
  end

  assign pwm_o      = pwm_q;
  assign act_full_q = (act_q >= PERIOD);
  assign act_lo_q   = act_full_q ? '0 : act_q[CNT_W-1:0];

  AST_FULL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_full_q |-> pwm_q); // R5

  AST_ZERO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == '0) |-> !pwm_q); // R4

  AST_DUTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_wrap_i |=> $stable(act_q)); // R6

  AST_PHASE_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CNT_W'(rise_cnt_i - fall_q) == act_lo_q); // R3

endmodule

// File: rtl/pwm_phase_bank.sv
// Bank of PWM channels sharing one period counter.
// rst_ni is asserted asynchronously and must be released synchronously upstream.
module pwm_phase_bank #(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned DUTY_W   = CNT_W + 1,
  parameter int unsigned DUTY_RST = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_en_i,
  input  logic [NUM_CH-1:0]        duty_load_i,
  input  logic [NUM_CH*DUTY_W-1:0] duty_i,
  output logic [NUM_CH-1:0]        pwm_o,
  output logic                     period_start_o
);

  import pwm_ps_pkg::*;

  logic [CNT_W-1:0] rise_cnt;
  logic             rise_wrap;
  logic             pstart_q, pstart_d;

  pwm_rise_ctr #(
    .CNT_W (CNT_W)
  ) rise_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_en_i (tick_en_i),
    .cnt_o     (rise_cnt),
    .wrap_o    (rise_wrap)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    localparam int unsigned LO = lane_lo(c, DUTY_W);
    pwm_fall_chan #(
      .CNT_W    (CNT_W),
      .DUTY_W   (DUTY_W),
      .DUTY_RST (DUTY_RST)
    ) chan_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_en_i   (tick_en_i),
      .rise_wrap_i (rise_wrap),
      .rise_cnt_i  (rise_cnt),
      .load_i      (duty_load_i[c]),
      .duty_i      (duty_i[LO +: DUTY_W]),
      .pwm_o       (pwm_o[c])
    );
  end

  always_comb begin
    pstart_d = rise_wrap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pstart_q <= 1'b0;
    end else begin
      pstart_q <= pstart_d;
    end
  end

  assign period_start_o = pstart_q;

  AST_PSTART_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_o |-> (rise_cnt == '0)); // R7

  AST_PSTART_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_en_i |=> !period_start_o); // R2

endmodule

// File: tb/pwm_phase_bank_tb.sv
module pwm_phase_bank_tb_top;

  localparam int unsigned CNT_W    = 4;
  localparam int unsigned NUM_CH   = 4;
  localparam int unsigned DW       = CNT_W + 1;
  localparam int unsigned P        = 1 << CNT_W;
  localparam int unsigned DUTY_RST = 8;

  logic                 clk;
  logic                 rst_n;
  logic                 tick_en;
  logic [NUM_CH-1:0]    load;
  logic [NUM_CH*DW-1:0] duty_bus;
  logic [NUM_CH-1:0]    pwm;
  logic                 pstart;

  int checks;
  int errors;
  bit done;

  int unsigned m_k;
  int unsigned m_pend [NUM_CH];
  int unsigned m_act  [NUM_CH];
  bit          m_recent [NUM_CH];
  bit          m_pstart;
  bit          m_tick_last;
  bit          m_first;

  pwm_phase_bank #(
    .CNT_W    (CNT_W),
    .NUM_CH   (NUM_CH),
    .DUTY_W   (DW),
    .DUTY_RST (DUTY_RST)
  ) dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .tick_en_i      (tick_en),
    .duty_load_i    (load),
    .duty_i         (duty_bus),
    .pwm_o          (pwm),
    .period_start_o (pstart)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit exp_pwm(input int unsigned act, input int unsigned k);
    if (act >= P) return 1'b1;
    return (k < act);
  endfunction

  task automatic check(input string req, input int ch, input bit got, input bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s ch%0d got %b expected %b (phase %0d)", req, ch, got, exp, m_k);
    end
  endtask

  task automatic compare_all();
    string tag;
    for (int c = 0; c < NUM_CH; c++) begin
      if (!m_tick_last) tag = "R2";
      else if (m_first) tag = "R1";
      else if (m_recent[c]) tag = "R6";
      else if (m_act[c] == 0) tag = "R4";
      else if (m_act[c] >= P) tag = "R5";
      else tag = "R3";
      check(tag, c, pwm[c], exp_pwm(m_act[c], m_k));
    end
    check(m_tick_last ? "R7" : "R2", -1, pstart, m_pstart);
  endtask

  task automatic model_update(input bit te, input logic [NUM_CH-1:0] ld,
                              input logic [NUM_CH*DW-1:0] dv);
    m_tick_last = te;
    m_pstart    = 1'b0;
    if (te) begin
      m_k = (m_k + 1) % P;
      if (m_k == 0) begin
        m_pstart = 1'b1;
        m_first  = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
          m_recent[c] = (m_act[c] != m_pend[c]);
          m_act[c]    = m_pend[c];
        end
      end
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (ld[c]) m_pend[c] = int'(dv[c*DW +: DW]);
    end
  endtask

  task automatic step(input bit te, input logic [NUM_CH-1:0] ld);
    @(negedge clk);
    compare_all();
    tick_en = te;
    load    = ld;
    @(posedge clk);
    model_update(te, ld, duty_bus);
  endtask

  function automatic int unsigned pick_duty();
    int unsigned r;
    r = $urandom % 8;
    case (r)
      0: return 0;
      1: return 1;
      2: return P - 1;
      3: return P;
      4: return (1 << DW) - 1;
      default: return $urandom % (1 << DW);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; tick_en = 1'b0; load = '0; duty_bus = '0;
    m_k = 0; m_pstart = 0; m_tick_last = 1; m_first = 1;
    for (int c = 0; c < NUM_CH; c++) begin
      m_pend[c] = DUTY_RST; m_act[c] = DUTY_RST; m_recent[c] = 0;
    end
    // R1: values held in reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", -1, &pwm, 1'b1);
    check("R1", -1, pstart, 1'b0);
    rst_n = 1'b1;

    // R1/R3: first periods with reset duty, continuous ticks
    for (int i = 0; i < 2 * P; i++) step(1'b1, '0);

    // R4/R5/R3/R6: extreme duty values, loaded mid-period
    duty_bus[0*DW +: DW] = DW'(0);
    duty_bus[1*DW +: DW] = DW'(P);
    duty_bus[2*DW +: DW] = DW'(1);
    duty_bus[3*DW +: DW] = DW'(P - 1);
    step(1'b1, 4'b1111);
    for (int i = 0; i < 3 * P; i++) step(1'b1, '0);

    // R6: load on the exact period-start clock goes to the following period
    while (m_k != P - 1) step(1'b1, '0);
    duty_bus[0*DW +: DW] = DW'(5);
    duty_bus[1*DW +: DW] = DW'((1 << DW) - 1);
    step(1'b1, 4'b0011);
    for (int i = 0; i < 3 * P; i++) step(1'b1, '0);

    // R2: tick enable held low for a long stretch
    for (int i = 0; i < 20; i++) step(1'b0, '0);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic [NUM_CH-1:0] ld;
      ld = '0;
      for (int c = 0; c < NUM_CH; c++) begin
        if ($urandom % 24 == 0) begin
          ld[c] = 1'b1;
          duty_bus[c*DW +: DW] = DW'(pick_duty());
        end
      end
      step(($urandom % 4) != 0, ld);
    end
    @(negedge clk);
    compare_all();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule